// File: doc/BRIEF.md
# Free-running timer counter with clock prescaler

The block holds a 16-bit timer count that runs freely from the moment reset is released. The count advances on a clock enable taken from one of seven taps of an internal power-of-two divider of the system clock, or from rising edges of an external clock input. That input is first brought into the system clock domain by a two-flop synchronizer. Software cannot stop the count and cannot load it in normal operation. A test mode input and a freeze mode input make the count writable. Freeze mode also halts its advance. This lets a debugger park the timer and lets production test preload it near the wrap point.

When an advance takes the count from 0xFFFF to 0x0000, a sticky overflow flag is set. An interrupt output follows the flag while an enable bit is set. A small register port has two word addresses. The read data is combinational, so a single 16-bit read always returns one whole, consistent count value. Address 0 is the count. Address 1 is a control word holding the flag, the interrupt enable and the 3-bit source select.

Top module: `gp_tick_counter`

## Requirements
- R1: After reset the count reads 0x0000, the overflow flag and interrupt enable are 0, and the source select code is 1, so the control word reads 0x0004.
- R2: Select code k from 0 to 6 advances the count once every 2^(k+1) system clocks. The divider is free running and starts at reset, so edge n after reset release (counting from 1) is an advance edge when n is a multiple of 2^(k+1). Code 1 is divide-by-4.
- R3: Select code 7 advances the count on the third system clock edge after the external input is first sampled high. High and low phases of two or more clocks are each counted. A pulse that starts and ends between two clock edges is never counted.
- R4: Reads have no side effect. reg_rdata is combinational on reg_addr. Address 0 returns the count. Address 1 returns bit 0 = overflow flag, bit 1 = interrupt enable, bits 4:2 = select code, and zeros above.
- R5: With test_mode and freeze_mode both low, a write to address 0 is ignored, and the count changes only by its normal advance.
- R6: With test_mode or freeze_mode high, a write to address 0 loads reg_wdata into the count on that clock edge, taking priority over an advance in the same cycle.
- R7: While freeze_mode is high the count does not advance; it changes only through writes.
- R8: An advance from 0xFFFF to 0x0000 sets the overflow flag. A load does not set it. The flag stays set until a write to address 1 with bit 0 = 1 clears it. An overflow in the same cycle as such a clear leaves the flag set.
- R9: irq is high exactly when the overflow flag and the interrupt enable (address 1, bit 1, writable at any time together with the select field) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_clk_in | input | 1 | External count source, asynchronous |
| test_mode | input | 1 | Makes the count writable while it keeps running |
| freeze_mode | input | 1 | Makes the count writable and halts its advance |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Word address: 0 count, 1 control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is a flag clear that lands in the same clock as a wrap. A prescaler tap alone gives no exact control over when the wrap happens. The stimulus therefore switches to the external source, preloads 0xFFFF in test mode while the input is idle, and raises the input. It then issues the clear write timed for the third edge, where the synchronized rising edge causes the advance. Randomized phases mix source changes, mode toggles, loads near the wrap point and a randomly toggling external input. A bench model predicts every count, flag and interrupt value from the requirements.

// File: rtl/gptc_pkg.sv
`timescale 1ns/100ps
package gptc_pkg;
  // word addresses of the register port
  localparam logic ADDR_COUNT = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;
  // control word field positions
  localparam int unsigned CTL_OVF_BIT = 0;
  localparam int unsigned CTL_IEN_BIT = 1;
  localparam int unsigned CTL_SEL_LSB = 2;
  // select code used after reset: divide-by-4 tap
  localparam int unsigned RESET_SEL_CODE = 1;
endpackage

// File: rtl/tc_prescaler.sv
`timescale 1ns/100ps
module tc_prescaler #(
  parameter int unsigned TAPS  = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_tick,
  output logic             tick
);
  logic [TAPS-1:0] div_q;
  logic [TAPS-1:0] div_d;
  logic [TAPS:0]   src;

  always_comb div_d = div_q + TAPS'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // tap k fires once every 2^(k+1) clocks
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign src[k] = &div_q[k:0];
  end
  assign src[TAPS] = ext_tick;

  assign tick = src[sel];
endmodule

// File: rtl/tc_ext_sync.sv
`timescale 1ns/100ps
module tc_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tc_count.sv
`timescale 1ns/100ps
module tc_count #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_en,
  input  logic         hold,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic [W-1:0] cnt_d;
  logic         step;

  always_comb begin
    step  = adv_en & ~hold & ~ld_en;
    cnt_d = count;
    if (ld_en)     cnt_d = ld_val;
    else if (step) cnt_d = count + W'(1);
  end

  assign wrap = step & (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end
endmodule

// File: rtl/tc_ctrl.sv
`timescale 1ns/100ps
module tc_ctrl #(
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned RST_SEL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_clr,
  input  logic             wr_ien,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wrap,
  output logic [SEL_W-1:0] sel_q,
  output logic             ien_q,
  output logic             ovf_q
);
  logic [SEL_W-1:0] sel_d;
  logic             ien_d;
  logic             ovf_d;

  always_comb begin
    sel_d = wr_en ? wr_sel : sel_q;
    ien_d = wr_en ? wr_ien : ien_q;
    // a new wrap outranks a clear in the same cycle
    if (wrap)                 ovf_d = 1'b1;
    else if (wr_en && wr_clr) ovf_d = 1'b0;
    else                      ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_W'(RST_SEL);
      ien_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      ien_q <= ien_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/gp_tick_counter.sv
`timescale 1ns/100ps
module gp_tick_counter
  import gptc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PRE_TAPS    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_in,
  input  logic             test_mode,
  input  logic             freeze_mode,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             ovf_flag,
  output logic             irq
);
  localparam int unsigned SEL_W = $clog2(PRE_TAPS + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_i;
  logic             ext_rise;
  logic             tick;
  logic             wr_count;
  logic             wr_ctrl;
  logic             wrap;
  logic             ien_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] count_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign wr_count = reg_wr & (reg_addr == ADDR_COUNT) & (test_mode | freeze_mode);
  assign wr_ctrl  = reg_wr & (reg_addr == ADDR_CTRL);

  tc_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i), .async_in(ext_clk_in), .rise(ext_rise)
  );

  tc_prescaler #(.TAPS(PRE_TAPS), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_i), .sel(sel_q), .ext_tick(ext_rise), .tick(tick)
  );

  tc_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i), .adv_en(tick), .hold(freeze_mode),
    .ld_en(wr_count), .ld_val(reg_wdata), .count(count_q), .wrap(wrap)
  );

  tc_ctrl #(.SEL_W(SEL_W), .RST_SEL(RESET_SEL_CODE)) u_ctl (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_ctrl),
    .wr_clr(reg_wdata[CTL_OVF_BIT]), .wr_ien(reg_wdata[CTL_IEN_BIT]),
    .wr_sel(reg_wdata[CTL_SEL_LSB +: SEL_W]), .wrap(wrap),
    .sel_q(sel_q), .ien_q(ien_q), .ovf_q(ovf_flag)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) begin
      reg_rdata[CTL_OVF_BIT]             = ovf_flag;
      reg_rdata[CTL_IEN_BIT]             = ien_q;
      reg_rdata[CTL_SEL_LSB +: SEL_W]    = sel_q;
    end else begin
      reg_rdata = count_q;
    end
  end

  assign irq = ovf_flag & ien_q;
endmodule

// File: rtl/tc_counter_chk.sv
`timescale 1ns/100ps
module tc_counter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_mode,
  input logic             freeze_mode,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             irq
);
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_mode && !(reg_wr && reg_addr == 1'b0)) |=> count == $past(count)); // R7

  AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !freeze_mode) |=> (count == $past(count) || count == $past(count) + CNT_W'(1))); // R5

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !freeze_mode && count == '1) |=> (count == '1 || ovf_flag)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(reg_wr && reg_addr == 1'b1 && reg_wdata[0])) |=> ovf_flag); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag); // R9
endmodule

bind gp_tick_counter tc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .freeze_mode(freeze_mode),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .count(count_q), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/gp_tick_counter_tb.sv
`timescale 1ns/100ps
module gp_tick_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk_in = 1'b0;
  logic        test_mode = 1'b0;
  logic        freeze_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ovf_flag;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit ext_rand = 1'b0;

  // bench model state
  logic        m_rs1, m_rs2;
  logic [15:0] m_cnt;
  logic        m_flag, m_en;
  logic [2:0]  m_sel;
  logic        m_e1, m_e2, m_e3;
  int          m_n;

  gp_tick_counter u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .test_mode(test_mode),
    .freeze_mode(freeze_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_flag(ovf_flag), .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic int tap_period(input logic [2:0] s);
    return 2 << s;   // R2: code k divides by 2^(k+1)
  endfunction

  function automatic logic [15:0] ctrl_word(input logic [2:0] s, input logic en, input logic f);
    return {11'b0, s, en, f};   // R4 layout
  endfunction

  // reference model, updated on each edge from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_cnt = 0; m_flag = 0; m_en = 0; m_sel = 3'd1;
      m_e1 = 0; m_e2 = 0; m_e3 = 0; m_n = 0;
    end else begin
      if (m_rs2) begin
        logic tk, wrc, wrs, wrp;
        m_n++;
        tk  = (m_sel == 3'd7) ? (m_e2 && !m_e3) : ((m_n % tap_period(m_sel)) == 0);
        wrc = reg_wr && reg_addr == 1'b0 && (test_mode || freeze_mode);
        wrs = reg_wr && reg_addr == 1'b1;
        wrp = 1'b0;
        if (wrc) m_cnt = reg_wdata;
        else if (tk && !freeze_mode) begin
          wrp = (m_cnt == 16'hFFFF);
          m_cnt = m_cnt + 16'd1;
        end
        if (wrp) m_flag = 1'b1;
        else if (wrs && reg_wdata[0]) m_flag = 1'b0;
        if (wrs) begin m_en = reg_wdata[1]; m_sel = reg_wdata[4:2]; end
        m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk_in;
      end
      m_rs2 = m_rs1; m_rs1 = 1'b1;
    end
  end

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // flag and interrupt compared every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      check({15'b0, ovf_flag}, {15'b0, m_flag}, "R8 flag");
      check({15'b0, irq}, {15'b0, m_flag & m_en}, "R9 irq");
    end
  end

  always @(negedge clk) if (ext_rand) ext_clk_in = 1'($urandom_range(0, 1));

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic a, input string tag);
    @(negedge clk); reg_addr = a; #1;
    check(reg_rdata, a ? ctrl_word(m_sel, m_en, m_flag) : m_cnt, tag);
  endtask

  initial begin
    logic [15:0] base;
    void'($urandom(32'h5EED_0042));
    idle(3);
    rst_n = 1'b1;
    #1 reg_addr = 1'b0; #0.5 check(reg_rdata, 16'h0000, "R1 count after reset");
    reg_addr = 1'b1; #0.5 check(reg_rdata, 16'h0004, "R1 control after reset");
    check({15'b0, irq}, 16'h0, "R1 irq after reset");

    idle(41); rd_chk(1'b0, "R2 divide-by-4 default");
    wr(1'b1, ctrl_word(3'd0, 1'b0, 1'b0)); idle(23); rd_chk(1'b0, "R2 divide-by-2");
    wr(1'b1, ctrl_word(3'd6, 1'b0, 1'b0)); idle(300); rd_chk(1'b0, "R2 divide-by-128");
    wr(1'b1, ctrl_word(3'd3, 1'b0, 1'b0)); idle(70); rd_chk(1'b0, "R2 divide-by-16");

    // R7 / R4: frozen count, repeated reads
    @(negedge clk); freeze_mode = 1'b1;
    idle(2); rd_chk(1'b0, "R4 read 1"); base = reg_rdata;
    rd_chk(1'b0, "R4 read 2"); idle(40);
    rd_chk(1'b0, "R7 frozen"); check(reg_rdata, base, "R7 frozen value");

    // R6 load, then R8 wrap
    wr(1'b0, 16'hFFFE); rd_chk(1'b0, "R6 load in freeze"); check(reg_rdata, 16'hFFFE, "R6 loaded value");
    wr(1'b1, ctrl_word(3'd0, 1'b0, 1'b0));
    @(negedge clk); freeze_mode = 1'b0;
    idle(10); rd_chk(1'b1, "R8 flag after wrap"); check(reg_rdata[0], 1'b1, "R8 flag set");
    wr(1'b1, ctrl_word(3'd0, 1'b1, 1'b0)); idle(1);
    check({15'b0, irq}, 16'h1, "R9 irq enabled");
    wr(1'b1, ctrl_word(3'd0, 1'b1, 1'b1)); rd_chk(1'b1, "R8 cleared");
    check({15'b0, ovf_flag}, 16'h0, "R8 clear");

    // R5: write ignored in normal mode
    wr(1'b0, 16'h1234); rd_chk(1'b0, "R5 write ignored");

    // R3 + R8 collision: clear and wrap on the same edge
    wr(1'b1, ctrl_word(3'd7, 1'b1, 1'b0));
    @(negedge clk); test_mode = 1'b1;
    wr(1'b0, 16'hFFFF);
    @(negedge clk); test_mode = 1'b0;
    idle(4);
    @(negedge clk); ext_clk_in = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = ctrl_word(3'd7, 1'b1, 1'b1);
    @(negedge clk); reg_wr = 1'b0;
    check({15'b0, ovf_flag}, 16'h1, "R8 set wins over clear");
    rd_chk(1'b0, "R3 external wrap"); check(reg_rdata, 16'h0000, "R3 wrapped to zero");

    // R3 glitch between edges is dropped
    @(negedge clk); ext_clk_in = 1'b0; idle(5);
    rd_chk(1'b0, "R3 before glitch"); base = reg_rdata;
    @(negedge clk); #0.5 ext_clk_in = 1'b1; #0.5 ext_clk_in = 1'b0;
    idle(6); rd_chk(1'b0, "R3 glitch"); check(reg_rdata, base, "R3 glitch dropped");

    // R3 five pulses of two clocks high, two low
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); ext_clk_in = 1'b1; @(negedge clk);
      @(negedge clk); ext_clk_in = 1'b0; @(negedge clk);
    end
    idle(4); rd_chk(1'b0, "R3 pulses"); check(reg_rdata, base + 16'd5, "R3 five pulses counted");

    // constrained random phase
    ext_rand = 1'b1;
    for (int i = 0; i < 500; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wr(1'b1, ctrl_word(($urandom_range(0, 3) == 0) ? 3'd7 : 3'($urandom_range(0, 3)),
                              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))));
        1: begin @(negedge clk); test_mode = 1'($urandom_range(0, 1)); end
        2: begin @(negedge clk); freeze_mode = ($urandom_range(0, 3) == 0); end
        3: wr(1'b0, $urandom_range(0, 1) ? {12'hFFF, 4'($urandom_range(0, 15))} : 16'($urandom));
        4: rd_chk(1'b0, "R4 random count read");
        5: rd_chk(1'b1, "R8 random control read");
        default: idle($urandom_range(1, 8));
      endcase
    end
    ext_rand = 1'b0;
    @(negedge clk); test_mode = 1'b0; freeze_mode = 1'b0;
    idle(20); rd_chk(1'b0, "R2 final count"); rd_chk(1'b1, "R9 final control");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule